// File: doc/BRIEF.md
# SPI Host Register Front End

This block is the register-mapped side of a serial peripheral host. A 32-bit word-addressed register port gives software a set of plain configuration registers, a transmit data register, a receive data register, two watermark registers and an interrupt enable/pending pair. Software writes bytes into an 8-entry transmit FIFO. A byte-exchange engine hands each queued byte to an external serial shifter through a valid/ready handshake and waits for the shifter's returned byte. Unless the direction bit is set, the returned byte goes into an 8-entry receive FIFO, which software drains through the receive data register.

Status is carried in bit 31 of the data registers themselves: transmit-full on the transmit side, receive-empty on the receive side. There is no separate status word. The two watermark comparisons differ on purpose. The transmit side flags when occupancy has fallen below its mark. The receive side flags when occupancy has risen above its mark. A single level-sensitive interrupt follows occupancy every cycle, with no acknowledge step.

A read takes effect in the cycle where `req_i` is high and `we_i` is low. `rdata_o` is valid combinationally in that cycle. Any pop caused by the read happens at the closing clock edge.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the clock divider (word offset 0x00) reads 0x3, delay0 (0x28) reads 0x1001 and delay1 (0x2C) reads 0x1. Every other register reads zero, both FIFOs are empty and `irq_o` is low.
- R2: The clock mode (0x04), chip-select id (0x10), chip-select default (0x14), chip-select mode (0x18), frame format (0x40) and interrupt enable (0x70) registers read back the full 32-bit value last written.
- R3: A write to tx data (0x48) pushes `wdata_i[7:0]` when the transmit FIFO holds fewer than 8 bytes. Otherwise the write is dropped. A read of 0x48 returns 0x8000_0000 when that FIFO is full and 0 otherwise.
- R4: A read of rx data (0x4C) returns 0x8000_0000 when the receive FIFO is empty. Otherwise it returns the oldest byte in bits 7:0 with bit 31 clear and removes that byte.
- R5: `xfer_valid_o` is high with the oldest transmit byte on `xfer_data_o` while the transmit FIFO is non-empty and no exchange is outstanding. A cycle with `xfer_valid_o` and `xfer_ready_i` both high removes the byte and opens an exchange. The exchange closes on the next cycle with `rx_valid_i` high. Bytes leave in write order.
- R6: While bit 3 of the frame format register is 1, a byte returned on `rx_data_i` is discarded.
- R7: A byte returned while the receive FIFO holds 8 bytes is discarded, and the stored bytes are kept.
- R8: Pending (0x74) bit 0 is 1 while the transmit count is less than the tx watermark (0x50). Bit 1 is 1 while the receive count is greater than the rx watermark (0x54). All other bits read 0.
- R9: `irq_o` is high exactly when some pending bit is 1 and the enable bit at the same position (bit 0 transmit, bit 1 receive) is 1.
- R10: A write of 8 or more to either watermark register leaves that register unchanged.
- R11: Writes to rx data (0x4C) and to the pending register (0x74) change nothing.
- R12: Every word offset not named in R1 to R4, R8 and R10 reads zero and ignores writes. This includes 0x08, 0x44 and 0x6C, and all offsets above 0x74.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address; bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during a read cycle |
| xfer_valid_o | output | 1 | Byte offered to the serial shifter |
| xfer_data_o | output | 8 | Byte offered to the serial shifter |
| xfer_ready_i | input | 1 | Shifter accepts the offered byte |
| rx_valid_i | input | 1 | Shifter returns a byte, closing the exchange |
| rx_data_i | input | 8 | Returned byte |
| irq_o | output | 1 | Watermark interrupt, level |

## Verification
The assertions assume that the shifter raises `rx_valid_i` only while an exchange it accepted is still open, and at most once per exchange. They also assume that `xfer_ready_i` is meaningful only while `xfer_valid_o` is high. The stimulus keeps within this by acting as the shifter in one fixed three-cycle sequence: ready in one cycle, the return strobe in the next, and both idle after that. Register accesses are single-cycle pulses, never held across edges.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned IX_DIV    = 0;
  localparam int unsigned IX_MODE   = 1;
  localparam int unsigned IX_CSID   = 4;
  localparam int unsigned IX_CSDEF  = 5;
  localparam int unsigned IX_CSMODE = 6;
  localparam int unsigned IX_DLY0   = 10;
  localparam int unsigned IX_DLY1   = 11;
  localparam int unsigned IX_FMT    = 16;
  localparam int unsigned IX_TXD    = 18;
  localparam int unsigned IX_RXD    = 19;
  localparam int unsigned IX_TXWM   = 20;
  localparam int unsigned IX_RXWM   = 21;
  localparam int unsigned IX_IE     = 28;
  localparam int unsigned IX_IP     = 29;

  localparam int unsigned N_PLAIN = 9;
  localparam int unsigned PLAIN_IX [N_PLAIN] =
    '{IX_DIV, IX_MODE, IX_CSID, IX_CSDEF, IX_CSMODE, IX_DLY0, IX_DLY1, IX_FMT, IX_IE};
  localparam logic [31:0] PLAIN_RST [N_PLAIN] =
    '{32'h3, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1001, 32'h1, 32'h0, 32'h0};
  // positions within the plain bank
  localparam int unsigned PL_FMT = 7;
  localparam int unsigned PL_IE  = 8;

  localparam int unsigned FMT_DIR_BIT = 3;
  localparam logic [31:0] FLAG_B31    = 32'h8000_0000;
endpackage

// File: rtl/shf_byte_fifo.sv
module shf_byte_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/shf_xchg_engine.sv
module shf_xchg_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_empty_i,
  input  logic [W-1:0] tx_head_i,
  output logic         tx_pop_o,
  input  logic         rx_full_i,
  input  logic         discard_i,
  output logic         rx_push_o,
  output logic [W-1:0] rx_byte_o,
  output logic         xfer_valid_o,
  output logic [W-1:0] xfer_data_o,
  input  logic         xfer_ready_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i
);
  logic busy_q;

  assign xfer_valid_o = !tx_empty_i && !busy_q;
  assign xfer_data_o  = tx_head_i;
  assign tx_pop_o     = xfer_valid_o && xfer_ready_i;
  // returned byte kept only when receiving and room exists
  assign rx_push_o    = busy_q && rx_valid_i && !discard_i && !rx_full_i;
  assign rx_byte_o    = rx_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_q <= 1'b0;
    else if (tx_pop_o)          busy_q <= 1'b1;
    else if (busy_q && rx_valid_i) busy_q <= 1'b0;
  end
endmodule

// File: rtl/shf_csr_bank.sv
module shf_csr_bank
  import spi_host_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      q_o [N_PLAIN]
);
  for (genvar g = 0; g < N_PLAIN; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q_o[g] <= PLAIN_RST[g];
      else if (we_i && idx_i == IDX_W'(PLAIN_IX[g])) q_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              xfer_valid_o,
  output logic [7:0]        xfer_data_o,
  input  logic              xfer_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              irq_o
);
  logic [IDX_W-1:0] widx;
  logic             wr_hit, rd_hit;
  logic [31:0]      plain_q [N_PLAIN];
  logic [CNT_W-1:0] tx_cnt, rx_cnt, txmark_q, rxmark_q;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic             tx_pop, rx_push, rx_pop, tx_push;
  logic             fmt_dir;
  logic [1:0]       pend, ena;
  logic             mark_ok;

  assign widx   = addr_i[ADDR_W-1:2];
  assign wr_hit = req_i && we_i;
  assign rd_hit = req_i && !we_i;

  shf_csr_bank #(.IDX_W(IDX_W)) i_bank (
    .clk_i, .rst_ni, .we_i(wr_hit), .idx_i(widx), .wdata_i, .q_o(plain_q)
  );

  assign fmt_dir = plain_q[PL_FMT][FMT_DIR_BIT];
  assign ena     = plain_q[PL_IE][1:0];

  assign tx_push = wr_hit && widx == IDX_W'(IX_TXD);
  assign rx_pop  = rd_hit && widx == IDX_W'(IX_RXD);

  shf_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_txf (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(wdata_i[7:0]), .pop_i(tx_pop),
    .head_o(tx_head), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  shf_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_rxf (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(rx_byte), .pop_i(rx_pop),
    .head_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  shf_xchg_engine #(.W(8)) i_eng (
    .clk_i, .rst_ni,
    .tx_empty_i(tx_empty), .tx_head_i(tx_head), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .discard_i(fmt_dir), .rx_push_o(rx_push), .rx_byte_o(rx_byte),
    .xfer_valid_o, .xfer_data_o, .xfer_ready_i, .rx_valid_i, .rx_data_i
  );

  // watermarks accept only values below the FIFO depth
  assign mark_ok = wdata_i < 32'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txmark_q <= '0;
      rxmark_q <= '0;
    end else if (wr_hit && mark_ok) begin
      if (widx == IDX_W'(IX_TXWM)) txmark_q <= wdata_i[CNT_W-1:0];
      if (widx == IDX_W'(IX_RXWM)) rxmark_q <= wdata_i[CNT_W-1:0];
    end
  end

  // asymmetric compares, re-evaluated every cycle
  assign pend[0] = tx_cnt < txmark_q;
  assign pend[1] = rx_cnt > rxmark_q;
  assign irq_o   = |(pend & ena);

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      unique case (1'b1)
        widx == IDX_W'(IX_TXD):  rdata_o = tx_full ? FLAG_B31 : 32'h0;
        widx == IDX_W'(IX_RXD):  rdata_o = rx_empty ? FLAG_B31 : {24'h0, rx_head};
        widx == IDX_W'(IX_TXWM): rdata_o = 32'(txmark_q);
        widx == IDX_W'(IX_RXWM): rdata_o = 32'(rxmark_q);
        widx == IDX_W'(IX_IP):   rdata_o = {30'h0, pend};
        default: begin
          for (int i = 0; i < N_PLAIN; i++)
            if (widx == IDX_W'(PLAIN_IX[i])) rdata_o = plain_q[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
  import spi_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              xfer_valid_o,
  input logic              xfer_ready_i,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  txmark_q,
  input logic [CNT_W-1:0]  rxmark_q,
  input logic              fmt_dir
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] widx;
  assign widx = addr_i[ADDR_W-1:2];

  // R3
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CNT_W'(DEPTH));

  // R3
  tx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx == IDX_W'(IX_TXD) && tx_cnt == CNT_W'(DEPTH))
    |=> tx_cnt <= $past(tx_cnt));

  // R4
  rx_empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && widx == IDX_W'(IX_RXD) && rx_cnt == '0) |-> rdata_o == FLAG_B31);

  // R5
  offer_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> tx_cnt != '0);

  // R5
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_ready_i) |=> !xfer_valid_o);

  // R6
  dir_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_dir |=> rx_cnt <= $past(rx_cnt));

  // R10
  txmark_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx == IDX_W'(IX_TXWM) && wdata_i >= 32'(DEPTH)) |=> $stable(txmark_q));

  // R10
  rxmark_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && widx == IDX_W'(IX_RXWM) && wdata_i >= 32'(DEPTH)) |=> $stable(rxmark_q));
endmodule

bind spi_host_regs spi_host_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
  .xfer_valid_o, .xfer_ready_i,
  .tx_cnt, .rx_cnt, .txmark_q, .rxmark_q, .fmt_dir
);

// File: tb/test_spi_host_regs.sv
`timescale 1ns/1ps
module test_spi_host_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        xfer_valid_o;
  logic [7:0]  xfer_data_o;
  logic        xfer_ready_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  spi_host_regs i_spi_host_regs (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #2 d = rdata_o;
    @(negedge clk_i);
    req_i = 0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // shifter model: accept offered byte, return ret one cycle later
  task automatic xchg(input string req, input logic [7:0] exp_tx, input logic [7:0] ret);
    @(negedge clk_i);
    xfer_ready_i = 1;
    #2;
    chk({req, " offer"}, {31'h0, xfer_valid_o}, 32'h1);
    chk({req, " byte"}, {24'h0, xfer_data_o}, {24'h0, exp_tx});
    @(negedge clk_i);
    xfer_ready_i = 0; rx_valid_i = 1; rx_data_i = ret;
    @(negedge clk_i);
    rx_valid_i = 0;
    #1;
  endtask

  task automatic t_reset;
    rd_chk("R1 div",   12'h000, 32'h3);
    rd_chk("R1 dly0",  12'h028, 32'h1001);
    rd_chk("R1 dly1",  12'h02C, 32'h1);
    rd_chk("R1 fmt",   12'h040, 32'h0);
    rd_chk("R1 ie",    12'h070, 32'h0);
    rd_chk("R1 txd",   12'h048, 32'h0);
    rd_chk("R1 rxd",   12'h04C, 32'h8000_0000);
    rd_chk("R1 ip",    12'h074, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_plain;
    wr(12'h004, 32'h0000_0003); rd_chk("R2 mode",   12'h004, 32'h3);
    wr(12'h010, 32'hDEAD_0001); rd_chk("R2 csid",   12'h010, 32'hDEAD_0001);
    wr(12'h014, 32'h1234_5678); rd_chk("R2 csdef",  12'h014, 32'h1234_5678);
    wr(12'h018, 32'h2);         rd_chk("R2 csmode", 12'h018, 32'h2);
    wr(12'h040, 32'hA5A5_0007); rd_chk("R2 fmt",    12'h040, 32'hA5A5_0007);
    wr(12'h040, 32'h0);
  endtask

  task automatic t_reserved;
    wr(12'h008, 32'hFFFF_FFFF); rd_chk("R12 0x08", 12'h008, 32'h0);
    wr(12'h044, 32'hFFFF_FFFF); rd_chk("R12 0x44", 12'h044, 32'h0);
    wr(12'h06C, 32'hFFFF_FFFF); rd_chk("R12 0x6C", 12'h06C, 32'h0);
    wr(12'h100, 32'hFFFF_FFFF); rd_chk("R12 0x100", 12'h100, 32'h0);
    rd_chk("R12 div kept", 12'h000, 32'h3);
  endtask

  task automatic t_fill_and_full;
    for (int i = 0; i < 9; i++) begin
      wr(12'h048, 32'hFFFF_FF00 | 32'(8'h10 + i));
      if (i == 6) rd_chk("R3 not full", 12'h048, 32'h0);
    end
    rd_chk("R3 full flag", 12'h048, 32'h8000_0000);
    for (int i = 0; i < 8; i++) xchg("R5", 8'(8'h10 + i), 8'(8'hA0 + i));
    chk("R3 9th dropped", {31'h0, xfer_valid_o}, 32'h0);
    // receive FIFO now full: one more returned byte must be lost
    wr(12'h048, 32'h77);
    xchg("R7", 8'h77, 8'h55);
    for (int i = 0; i < 8; i++) rd_chk("R4 order", 12'h04C, 32'(8'hA0 + i));
    rd_chk("R7 extra dropped", 12'h04C, 32'h8000_0000);
  endtask

  task automatic t_dir;
    wr(12'h040, 32'h8);
    wr(12'h048, 32'h3C);
    xchg("R6", 8'h3C, 8'h99);
    rd_chk("R6 discarded", 12'h04C, 32'h8000_0000);
    wr(12'h040, 32'h0);
  endtask

  task automatic t_marks;
    wr(12'h050, 32'h2);
    rd_chk("R8 tx below", 12'h074, 32'h1);
    wr(12'h070, 32'h1);
    chk("R9 tx irq", {31'h0, irq_o}, 32'h1);
    wr(12'h048, 32'h01);
    wr(12'h048, 32'h02);
    rd_chk("R8 tx at mark", 12'h074, 32'h0);
    chk("R9 irq low", {31'h0, irq_o}, 32'h0);
    wr(12'h054, 32'h1);
    xchg("R8", 8'h01, 8'h11);
    xchg("R8", 8'h02, 8'h22);
    rd_chk("R8 both", 12'h074, 32'h3);
    wr(12'h070, 32'h2);
    chk("R9 rx irq", {31'h0, irq_o}, 32'h1);
    wr(12'h070, 32'h0);
    chk("R9 masked", {31'h0, irq_o}, 32'h0);
    wr(12'h050, 32'h8); rd_chk("R10 txmark kept", 12'h050, 32'h2);
    wr(12'h054, 32'h9); rd_chk("R10 rxmark kept", 12'h054, 32'h1);
    wr(12'h050, 32'h7); rd_chk("R10 txmark 7", 12'h050, 32'h7);
    wr(12'h050, 32'h2);
    wr(12'h04C, 32'h77);
    wr(12'h074, 32'h0);
    rd_chk("R11 ip kept", 12'h074, 32'h3);
    rd_chk("R11 rx first", 12'h04C, 32'h11);
    rd_chk("R11 rx second", 12'h04C, 32'h22);
    rd_chk("R11 rx empty", 12'h04C, 32'h8000_0000);
    wr(12'h050, 32'h0);
    wr(12'h054, 32'h0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_plain();
    t_reserved();
    t_fill_and_full();
    t_dir();
    t_marks();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule